// File: doc/BRIEF.md
# NOR Flash Word-Program Sequencer

This block sits on the host side of a parallel NOR flash and writes one bus word into it. A request carries a target address and a data word, and it is accepted only while the block is idle. The block first reads the target location. If that location already holds the requested value, the request finishes at once and sends no command. Otherwise the block issues the three-cycle unlock-and-program command preamble and then the data write. It waits the typical program time and then polls the target until two back-to-back reads agree, which means no status bit is toggling any more.

If polling runs past a timeout, the block writes the reset command to address zero and starts the whole command preamble again. After a bounded number of such retries it reports an error. Completion is a one-cycle `done` pulse, and `err` is valid in that same cycle.

The flash bus is a simple synchronous one. A write is one cycle with `fl_we` high. A read is one cycle with `fl_re` high, and the word appears on `fl_rdata` in the following cycle.

States: IDLE (waits for a request) → PRE_RD (issues the pre-read) → PRE_CMP (compares the pre-read with the request data; equal goes to DONE, different goes to UNL1) → UNL1 → UNL2 → PGM_CMD → PGM_DATA (command and data writes) → WAIT_TYP (typical program time elapsed → POLL_RD1) → POLL_RD1 → POLL_RD2 → POLL_CMP. From POLL_CMP, equal reads go to DONE, a timeout goes to RESET, and otherwise the block goes to POLL_GAP. POLL_GAP moves to POLL_RD1 on the next microsecond tick. RESET goes to UNL1 while retries remain, or to DONE with an error once they are exhausted. DONE goes to IDLE.

Top module: `nor_word_programmer`

## Requirements
- R1: When the pre-read word equals the request data, the block pulses `done` with `err`=0 and issues no bus write.
- R2: A program attempt writes, in this order: 0x00AA to the first unlock address, 0x0055 to the second unlock address, 0x00A0 to the first unlock address, and then the data word to the target address.
- R3: With `wide_compat`=0 the first and second unlock addresses are 0x555 and 0x2AA. With `wide_compat`=1 they are 0xAAA and 0x555.
- R4: Each command word carries its command byte in bits 7:0, and all upper bits are zero.
- R5: No read is issued until at least 2^PROG_LOG2 microseconds (each TICKS_PER_US clocks) after the data write.
- R6: The block finishes with `err`=0 when two consecutive reads of the target return the same word.
- R7: Polling of one attempt ends in a timeout after about TIMEOUT_US microseconds of unequal read pairs. Read pairs are spaced by one microsecond tick.
- R8: On a timeout the block writes 0x00F0 to address 0 and then restarts from the first unlock write.
- R9: After MAX_RETRIES retries (MAX_RETRIES+1 attempts) that all time out, the block pulses `done` with `err`=1.
- R10: A request is accepted only when `req_ready` is high. `req_valid` during an operation has no effect.
- R11: `done` is high for exactly one cycle, `err` is high only together with `done`, and `req_ready` rises the cycle after `done`.
- R12: After reset the block is idle: `req_ready`=1 and `fl_we`, `fl_re`, `done` are 0.
- R13: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_compat | input | 1 | Selects the compatibility unlock address pair |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High while idle; a request is taken when both are high |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | BUS_W | Word to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with `done` |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | BUS_W | Flash bus write data |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus read strobe |
| fl_rdata | input | BUS_W | Flash bus read data, valid the cycle after `fl_re` |

## Verification
On every cycle, the assertions check the handshake and pulse rules: the strobes are exclusive, `done` lasts one cycle, `err` is confined to `done`, the return to idle follows `done`, and the bus is quiet while idle. The command order, the unlock address pair chosen by the mode, the skip of equal data, the typical-wait spacing, the timeout window and the retry count only show in the bench's scenarios. There, a behavioural flash model decodes each write, toggles a status bit while busy, and records the spacing between the data write, the first poll read and each reset command.

// File: rtl/nwp_pkg.sv
package nwp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_RD,
        S_PRE_CMP,
        S_UNL1,
        S_UNL2,
        S_PGM_CMD,
        S_PGM_DATA,
        S_WAIT_TYP,
        S_POLL_RD1,
        S_POLL_RD2,
        S_POLL_CMP,
        S_POLL_GAP,
        S_RESET,
        S_DONE
    } nwp_state_t;

    localparam logic [7:0]  CMD_KEY_A    = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B    = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0]  CMD_RESET    = 8'hF0;

    localparam logic [11:0] KEY_ADDR_A_STD  = 12'h555;
    localparam logic [11:0] KEY_ADDR_B_STD  = 12'h2AA;
    localparam logic [11:0] KEY_ADDR_A_WIDE = 12'hAAA;
    localparam logic [11:0] KEY_ADDR_B_WIDE = 12'h555;

endpackage

// File: rtl/nwp_tick_gen.sv
module nwp_tick_gen #(
    parameter int TICKS_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICKS_PER_US > 2) ? $clog2(TICKS_PER_US) : 1;

    logic [PW-1:0] pre_q;

    assign tick = (pre_q == PW'(TICKS_PER_US - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/nwp_us_counter.sv
module nwp_us_counter #(
    parameter int LIMIT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       tick,
    output logic [$clog2(LIMIT+1)-1:0] count
);
    localparam int CW = $clog2(LIMIT + 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick && (count != CW'(LIMIT))) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/nor_word_programmer.sv
module nor_word_programmer #(
    parameter int ADDR_W       = 12,
    parameter int BUS_W        = 16,
    parameter int TICKS_PER_US = 50,
    parameter int PROG_LOG2    = 3,
    parameter int TIMEOUT_US   = 16,
    parameter int MAX_RETRIES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_compat,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_data,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [BUS_W-1:0]  fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [BUS_W-1:0]  fl_rdata
);
    import nwp_pkg::*;

    localparam int PROG_US = 1 << PROG_LOG2;
    localparam int LIMIT   = (PROG_US > TIMEOUT_US) ? PROG_US : TIMEOUT_US;
    localparam int CW      = $clog2(LIMIT + 1);
    localparam int RW      = $clog2(MAX_RETRIES + 1);

    nwp_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  data_q;
    logic [BUS_W-1:0]  first_q;
    logic              mode_q;
    logic              err_q;
    logic [RW-1:0]     retry_q;

    logic              tick;
    logic              tmr_clr;
    logic [CW-1:0]     us_cnt;
    logic              wait_over;
    logic              timed_out;
    logic              retries_left;

    function automatic logic [BUS_W-1:0] cmd_word(input logic [7:0] code);
        cmd_word = {{(BUS_W-8){1'b0}}, code};
    endfunction

    assign wait_over    = (us_cnt >= CW'(PROG_US));
    assign timed_out    = (us_cnt >= CW'(TIMEOUT_US));
    assign retries_left = (retry_q != RW'(MAX_RETRIES));
    assign tmr_clr      = (state_q == S_PGM_DATA) ||
                          ((state_q == S_WAIT_TYP) && wait_over);

    nwp_tick_gen #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick)
    );

    nwp_us_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .tick (tick),
        .count(us_cnt)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_PRE_RD;
            S_PRE_RD:   state_d = S_PRE_CMP;
            S_PRE_CMP:  state_d = (fl_rdata == data_q) ? S_DONE : S_UNL1;
            S_UNL1:     state_d = S_UNL2;
            S_UNL2:     state_d = S_PGM_CMD;
            S_PGM_CMD:  state_d = S_PGM_DATA;
            S_PGM_DATA: state_d = S_WAIT_TYP;
            S_WAIT_TYP: if (wait_over) state_d = S_POLL_RD1;
            S_POLL_RD1: state_d = S_POLL_RD2;
            S_POLL_RD2: state_d = S_POLL_CMP;
            S_POLL_CMP: begin
                if (fl_rdata == first_q) state_d = S_DONE;
                else if (timed_out)      state_d = S_RESET;
                else                     state_d = S_POLL_GAP;
            end
            S_POLL_GAP: if (tick) state_d = S_POLL_RD1;
            S_RESET:    state_d = retries_left ? S_UNL1 : S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request and attempt bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            first_q <= '0;
            mode_q  <= 1'b0;
            err_q   <= 1'b0;
            retry_q <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                addr_q  <= req_addr;
                data_q  <= req_data;
                mode_q  <= wide_compat;
                err_q   <= 1'b0;
                retry_q <= '0;
            end
            if (state_q == S_POLL_RD2) first_q <= fl_rdata;
            if (state_q == S_RESET) begin
                if (retries_left) retry_q <= retry_q + 1'b1;
                else              err_q   <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        fl_addr   = '0;
        fl_wdata  = '0;
        fl_we     = 1'b0;
        fl_re     = 1'b0;
        unique case (state_q)
            S_IDLE:     req_ready = 1'b1;
            S_PRE_RD, S_POLL_RD1, S_POLL_RD2: begin
                fl_re   = 1'b1;
                fl_addr = addr_q;
            end
            S_UNL1, S_PGM_CMD: begin
                fl_we    = 1'b1;
                fl_addr  = ADDR_W'(mode_q ? KEY_ADDR_A_WIDE : KEY_ADDR_A_STD);
                fl_wdata = cmd_word((state_q == S_UNL1) ? CMD_KEY_A : CMD_PROGRAM);
            end
            S_UNL2: begin
                fl_we    = 1'b1;
                fl_addr  = ADDR_W'(mode_q ? KEY_ADDR_B_WIDE : KEY_ADDR_B_STD);
                fl_wdata = cmd_word(CMD_KEY_B);
            end
            S_PGM_DATA: begin
                fl_we    = 1'b1;
                fl_addr  = addr_q;
                fl_wdata = data_q;
            end
            S_RESET: begin
                fl_we    = 1'b1;
                fl_wdata = cmd_word(CMD_RESET);
            end
            S_DONE: begin
                done = 1'b1;
                err  = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nwp_checker.sv
module nwp_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic err,
    input logic fl_we,
    input logic fl_re
);
    p_bus_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_back_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(fl_we || fl_re || done));
endmodule

bind nor_word_programmer nwp_checker u_nwp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .done     (done),
    .err      (err),
    .fl_we    (fl_we),
    .fl_re    (fl_re)
);

// File: tb/nor_word_programmer_test.sv
module nor_word_programmer_test;
    localparam int AW = 12;
    localparam int BW = 16;
    localparam int TPU = 50;
    localparam int PLOG = 3;
    localparam int TMO = 16;
    localparam int RTY = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_compat = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_data = '0;
    logic          done, err;
    logic [AW-1:0] fl_addr;
    logic [BW-1:0] fl_wdata;
    logic          fl_we, fl_re;
    logic [BW-1:0] fl_rdata;

    always #10 clk = ~clk;

    nor_word_programmer #(
        .ADDR_W(AW), .BUS_W(BW), .TICKS_PER_US(TPU),
        .PROG_LOG2(PLOG), .TIMEOUT_US(TMO), .MAX_RETRIES(RTY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wide_compat(wide_compat),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .done(done), .err(err),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    // ---------------- behavioural flash model ----------------
    logic [BW-1:0] mem [16];
    int  busy_len = 100;
    int  busy = 0;
    int  seq = 0;
    bit  tog = 0;
    longint cyc = 0;
    int  wr_cnt = 0, prog_cnt = 0, f0_cnt = 0, bad_cnt = 0;
    longint data_cyc = 0, poll_cyc = 0;
    bit  want_first = 0;
    int  wait_gap = 0, f0_gap = 0;
    logic [BW-1:0] rd_q = '0;
    assign fl_rdata = rd_q;

    function automatic logic [AW-1:0] key_a(bit m);
        return m ? 12'hAAA : 12'h555;
    endfunction
    function automatic logic [AW-1:0] key_b(bit m);
        return m ? 12'h555 : 12'h2AA;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 16'hFFFF;
            busy <= 0; seq <= 0;
        end else begin
            if (fl_we) begin
                wr_cnt <= wr_cnt + 1;
                if (seq == 3) begin
                    mem[fl_addr[3:0]] <= fl_wdata;
                    busy <= busy_len; seq <= 0;
                    data_cyc <= cyc; want_first <= 1'b1;
                end else if (fl_wdata == 16'h00F0) begin
                    if (fl_addr == '0) f0_cnt <= f0_cnt + 1;
                    else               bad_cnt <= bad_cnt + 1;
                    f0_gap <= int'(cyc - poll_cyc);
                    busy <= 0; seq <= 0;
                end else if (busy > 0) begin
                    bad_cnt <= bad_cnt + 1;
                end else if (seq == 0 && fl_addr == key_a(wide_compat) && fl_wdata == 16'h00AA) begin
                    seq <= 1;
                end else if (seq == 1 && fl_addr == key_b(wide_compat) && fl_wdata == 16'h0055) begin
                    seq <= 2;
                end else if (seq == 2 && fl_addr == key_a(wide_compat) && fl_wdata == 16'h00A0) begin
                    seq <= 3; prog_cnt <= prog_cnt + 1;
                end else begin
                    bad_cnt <= bad_cnt + 1; seq <= 0;
                end
            end else if (busy > 0) begin
                busy <= busy - 1;
            end
            if (fl_re) begin
                if (busy > 0) begin
                    rd_q <= mem[fl_addr[3:0]] ^ (tog ? 16'h0040 : 16'h0000);
                    tog  <= ~tog;
                end else begin
                    rd_q <= mem[fl_addr[3:0]];
                end
                if (want_first) begin
                    want_first <= 1'b0;
                    wait_gap   <= int'(cyc - data_cyc);
                    poll_cyc   <= cyc;
                end
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;
    logic [BW-1:0] shadow [16];
    int d_wr, d_prog, d_f0, d_bad;
    bit last_err, pulse_ok;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    task automatic run_req(input int idx, input logic [BW-1:0] d, input bit mode,
                           input int blen, input bit noise);
        int w0, p0, f0, b0, cnt;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
        wide_compat = mode; busy_len = blen;
        w0 = wr_cnt; p0 = prog_cnt; f0 = f0_cnt; b0 = bad_cnt;
        req_addr = AW'(12'h100 + idx); req_data = d; req_valid = 1'b1;
        @(negedge clk);
        if (noise) begin
            req_data = ~d; req_addr = 12'h10F;
        end else begin
            req_valid = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 20000) begin
            @(negedge clk);
            cnt++;
            if (cnt == 40) req_valid = 1'b0;
        end
        req_valid = 1'b0;
        last_err = err;
        chk(done == 1'b1, "R11 done reached", done, 1);
        @(negedge clk);
        pulse_ok = !done && req_ready;
        chk(pulse_ok, "R11 one-cycle done then ready", {done, req_ready}, 2'b01);
        d_wr = wr_cnt - w0; d_prog = prog_cnt - p0;
        d_f0 = f0_cnt - f0; d_bad = bad_cnt - b0;
    endtask

    task automatic expect_ok(input int idx, input logic [BW-1:0] d, input bit skip);
        chk(last_err == 1'b0, "R6 err clear", last_err, 0);
        chk(mem[idx] == d, "R6 word stored", mem[idx], d);
        chk(d_bad == 0, "R2 R3 R4 command sequence", d_bad, 0);
        if (skip) chk(d_wr == 0, "R1 no writes on equal data", d_wr, 0);
        else begin
            chk(d_prog == 1 && d_f0 == 0, "R2 one program attempt", d_prog, 1);
            chk(wait_gap >= (1 << PLOG) * TPU, "R5 typical wait", wait_gap, (1 << PLOG) * TPU);
        end
        shadow[idx] = d;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk(req_ready && !fl_we && !fl_re && !done, "R12 reset idle",
            {req_ready, fl_we, fl_re, done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !fl_we && !fl_re && !done, "R12 idle after reset",
            {req_ready, fl_we, fl_re, done}, 4'b1000);

        // R2 R5 R6: standard mode, finishes before first poll
        run_req(0, 16'h1234, 1'b0, 200, 1'b0);
        expect_ok(0, 16'h1234, 1'b0);

        // R3: compatibility unlock addresses, several poll pairs
        run_req(1, 16'hABCD, 1'b1, 900, 1'b0);
        expect_ok(1, 16'hABCD, 1'b0);

        // R1: same data again
        run_req(0, 16'h1234, 1'b0, 200, 1'b0);
        expect_ok(0, 16'h1234, 1'b1);

        // R7 R8 R9: device never finishes
        run_req(2, 16'h5A5A, 1'b0, 1000000, 1'b0);
        chk(last_err == 1'b1, "R9 error after retries", last_err, 1);
        chk(d_prog == RTY + 1, "R9 attempt count", d_prog, RTY + 1);
        chk(d_f0 == RTY + 1, "R8 reset writes to address 0", d_f0, RTY + 1);
        chk(d_bad == 0, "R8 restart from first unlock", d_bad, 0);
        chk(f0_gap >= (TMO - 1) * TPU && f0_gap <= (TMO + 2) * TPU,
            "R7 timeout window", f0_gap, TMO * TPU);
        shadow[2] = 16'h5A5A;

        // R10: request held during operation is ignored
        run_req(3, 16'h0F0F, 1'b0, 300, 1'b1);
        expect_ok(3, 16'h0F0F, 1'b0);
        chk(mem[15] == shadow[15], "R10 ignored request left word", mem[15], shadow[15]);

        // random mix
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h1F2E3D4C);
        end
        for (int k = 0; k < 24; k++) begin
            int idx, bl;
            bit md, sk;
            logic [BW-1:0] d;
            idx = $urandom_range(0, 14);
            md  = 1'($urandom_range(0, 1));
            sk  = ($urandom_range(0, 3) == 0);
            bl  = $urandom_range(20, 1000);
            d   = sk ? shadow[idx] : BW'($urandom);
            if (d == shadow[idx]) sk = 1'b1;
            run_req(idx, d, md, bl, 1'b0);
            expect_ok(idx, d, sk);
        end

        finish_run();
    end
endmodule